// File: doc/BRIEF.md
# Circular Delay-Line Address Generator

This block produces the external sample-memory addresses for an audio processor that runs a fixed program of 128 steps for every output sample. On each step the program supplies a 6-bit pointer into a 64-entry table of word offsets, along with three address modifiers and two request bits: one modifier adds the processor's address register, one adds one word, and one selects table mode. Outside table mode, a per-sample down counter is added and the sum is wrapped by a programmable ring mask. This makes a plain memory region behave as a set of delay lines that move one word per sample. In table mode the counter is left out, so fixed lookup data can be reached.

Only odd steps (counting from zero) can request a memory access. A request made at step x shows up on the memory port during step x+1, and the read word is captured at the end of that step, sign-extended to 24 bits, and is available from step x+2 on. The same counter also rotates the index of the processor's 128-entry temporary register file, so those registers move with the delay lines. An input `step_en` paces the steps. A 2-flop synchronizer releases the asynchronous reset.

Top module: `ring_agu`

## Requirements
- R1: The word sum is the offset table entry chosen by `op_idx`, plus `areg` when `op_use_areg` is 1, plus 1 when `op_next_word` is 1.
- R2: When `op_tbl_mode` is 0 (ring mode), the sample counter is added to the word sum and the result is ANDed with the ring-mask register.
- R3: When `op_tbl_mode` is 1 (table mode), the counter is not added and the word sum is truncated to 16 bits.
- R4: `mem_addr` is the base register plus twice the masked word, kept to the low `MEM_AW` (21) bits.
- R5: The address register and the request flags load only on steps whose index has bit 0 set. On even steps the request inputs are ignored, and `mem_addr` keeps its value.
- R6: A read or write requested at step x drives `mem_rd` or `mem_wr` high for step x+1 only.
- R7: At the end of a step in which `mem_rd` is high, `mem_rdata` is captured sign-extended from bit 15 to 24 bits on `rd_data`. `rd_data` holds its value at all other times.
- R8: The sample counter decrements after step 127. When the result would be 0, the counter reloads with the ring-mask register instead.
- R9: After reset the counter is 1, the ring-mask register is 0x1FFF, the base is 0, all offset entries are 0, the step index is 0, and `mem_addr`, `mem_rd`, `mem_wr` and `rd_data` are 0.
- R10: `treg_idx` equals (counter + `op_treg`) modulo 128.
- R11: An offset entry written through `tbl_we` is used from the next clock on. A step that reads the same entry in the same clock sees the old value. The ring-mask and base registers written through `len_we` and `base_we` also take effect from the next clock.
- R12: While `step_en` is 0, the step index, the counter, the request flags and `rd_data` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advances one program step |
| op_idx | input | 6 | Offset table pointer of the current step |
| op_use_areg | input | 1 | Add `areg` to the word sum |
| op_next_word | input | 1 | Add one to the word sum |
| op_tbl_mode | input | 1 | 1 = table mode, 0 = ring mode |
| op_rd_req | input | 1 | Request a memory read |
| op_wr_req | input | 1 | Request a memory write |
| op_treg | input | 7 | Temporary register number |
| areg | input | 12 | Processor address register |
| tbl_we | input | 1 | Offset table write strobe |
| tbl_waddr | input | 6 | Offset table write entry |
| tbl_wdata | input | 16 | Offset table write value |
| len_we | input | 1 | Ring-mask register write strobe |
| len_wdata | input | 16 | Ring-mask value (ring length minus one) |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 21 | Base byte address |
| mem_rdata | input | 16 | Read word from sample memory |
| mem_addr | output | 21 | Byte address to sample memory |
| mem_rd | output | 1 | Read access strobe |
| mem_wr | output | 1 | Write access strobe |
| rd_data | output | 24 | Last read word, sign-extended |
| treg_idx | output | 7 | Rotated temporary register index |

## Verification
The bench goes after the sample boundary where the counter passes 1. A design that reloads one count late, or reloads with the wrong value, shifts every ring address in the next sample and rotates `treg_idx` wrongly. With a small ring mask, word sums wrap past the mask and table-mode sums carry out of 16 bits. A mask applied in the wrong mode, or a carry that is not dropped, lands on the wrong byte address. Requests raised on even steps must not reach the port, and requests must not slip by a step. Random stalls check that nothing advances while `step_en` is 0. Table writes aimed at the entry being read in the same clock expose a design that forwards the new value early. Negative memory words expose capture without sign extension.

// File: rtl/ring_agu_pkg.sv
package ring_agu_pkg;

  // Address mode carried by each program step.
  typedef enum logic {
    ADDR_RING  = 1'b0,
    ADDR_TABLE = 1'b1
  } addr_mode_e;

  // Memory request pair of one step.
  typedef struct packed {
    logic rd;
    logic wr;
  } mem_req_t;

endpackage

// File: rtl/ring_offset_table.sv
module ring_offset_table #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] ent_arr [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [DW-1:0] ent_d;
    logic [DW-1:0] ent_q;

    always_comb begin
      ent_d = ent_q;
      if (we && (waddr == AW'(e))) ent_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end

    assign ent_arr[e] = ent_q;
  end

  // Registered entries: a same-clock write is seen one clock later.
  assign rdata = ent_arr[raddr];

endmodule

// File: rtl/ring_sequencer.sv
module ring_sequencer #(
  parameter int              STEPS   = 128,
  parameter int              CNT_W   = 16,
  parameter int              MEM_AW  = 21,
  parameter logic [CNT_W-1:0] LEN_RST = 16'h1FFF,
  parameter int              STEP_W  = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              len_we,
  input  logic [CNT_W-1:0]  len_wdata,
  input  logic              base_we,
  input  logic [MEM_AW-1:0] base_wdata,
  output logic [STEP_W-1:0] step_idx,
  output logic              step_odd,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  ring_mask,
  output logic [MEM_AW-1:0] base
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] step_d, step_q;
  logic [CNT_W-1:0]  cnt_d, cnt_q, cnt_dec;
  logic [CNT_W-1:0]  len_d, len_q;
  logic [MEM_AW-1:0] base_d, base_q;
  logic              last_step;

  assign last_step = (step_q == LAST_STEP);
  assign cnt_dec   = cnt_q - 1'b1;

  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    base_d = base_q;
    if (step_en) begin
      step_d = last_step ? '0 : step_q + 1'b1;
      if (last_step) cnt_d = (cnt_dec == '0) ? len_q : cnt_dec;
    end
    if (len_we)  len_d  = len_wdata;
    if (base_we) base_d = base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      cnt_q  <= CNT_W'(1);
      len_q  <= LEN_RST;
      base_q <= '0;
    end else begin
      step_q <= step_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      base_q <= base_d;
    end
  end

  assign step_idx  = step_q;
  assign step_odd  = step_q[0];
  assign cnt       = cnt_q;
  assign ring_mask = len_q;
  assign base      = base_q;

endmodule

// File: rtl/ring_addr_unit.sv
module ring_addr_unit
  import ring_agu_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int AREG_W = 12,
  parameter int MEM_AW = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OFS_W-1:0]  offset,
  input  logic [AREG_W-1:0] areg,
  input  logic              use_areg,
  input  logic              next_word,
  input  addr_mode_e        mode,
  input  logic [OFS_W-1:0]  cnt,
  input  logic [OFS_W-1:0]  ring_mask,
  input  logic [MEM_AW-1:0] base,
  output logic [MEM_AW-1:0] addr
);

  localparam int PAD_W = MEM_AW - OFS_W - 1;

  logic [OFS_W:0]    word_sum, ring_sum;
  logic [OFS_W-1:0]  sel_word;
  logic [MEM_AW-1:0] byte_addr, addr_d, addr_q;

  always_comb begin
    word_sum = {1'b0, offset}
             + (use_areg ? (OFS_W+1)'(areg) : '0)
             + (OFS_W+1)'(next_word);
    ring_sum = word_sum + {1'b0, cnt};
    if (mode == ADDR_TABLE) sel_word = word_sum[OFS_W-1:0];
    else                    sel_word = ring_sum[OFS_W-1:0] & ring_mask;
    // Truncation to MEM_AW applies the memory size mask.
    byte_addr = base + {{PAD_W{1'b0}}, sel_word, 1'b0};
    addr_d    = load ? byte_addr : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/ring_req_pipe.sv
module ring_req_pipe
  import ring_agu_pkg::*;
#(
  parameter int MDW = 16,
  parameter int XW  = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_en,
  input  logic           step_odd,
  input  mem_req_t       req,
  input  logic [MDW-1:0] mem_rdata,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [XW-1:0]  rd_word
);

  mem_req_t       act_d, act_q;
  logic [XW-1:0]  word_d, word_q;

  always_comb begin
    act_d  = act_q;
    word_d = word_q;
    if (step_en) begin
      act_d.rd = step_odd & req.rd;
      act_d.wr = step_odd & req.wr;
      if (act_q.rd) word_d = {{(XW-MDW){mem_rdata[MDW-1]}}, mem_rdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      word_q <= '0;
    end else begin
      act_q  <= act_d;
      word_q <= word_d;
    end
  end

  assign mem_rd  = act_q.rd;
  assign mem_wr  = act_q.wr;
  assign rd_word = word_q;

endmodule

// File: rtl/ring_agu.sv
module ring_agu
  import ring_agu_pkg::*;
#(
  parameter int STEPS       = 128,
  parameter int TBL_DEPTH   = 64,
  parameter int OFS_W       = 16,
  parameter int AREG_W      = 12,
  parameter int MEM_AW      = 21,
  parameter int MDW         = 16,
  parameter int XW          = 24,
  parameter int TEMP_DEPTH  = 128,
  parameter int TBL_AW      = $clog2(TBL_DEPTH),
  parameter int TEMP_W      = $clog2(TEMP_DEPTH),
  parameter int STEP_W      = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [TBL_AW-1:0] op_idx,
  input  logic              op_use_areg,
  input  logic              op_next_word,
  input  logic              op_tbl_mode,
  input  logic              op_rd_req,
  input  logic              op_wr_req,
  input  logic [TEMP_W-1:0] op_treg,
  input  logic [AREG_W-1:0] areg,
  input  logic              tbl_we,
  input  logic [TBL_AW-1:0] tbl_waddr,
  input  logic [OFS_W-1:0]  tbl_wdata,
  input  logic              len_we,
  input  logic [OFS_W-1:0]  len_wdata,
  input  logic              base_we,
  input  logic [MEM_AW-1:0] base_wdata,
  input  logic [MDW-1:0]    mem_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [XW-1:0]     rd_data,
  output logic [TEMP_W-1:0] treg_idx
);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [STEP_W-1:0] step_idx;
  logic              step_odd;
  logic [OFS_W-1:0]  cnt, ring_mask, offset;
  logic [MEM_AW-1:0] base;
  addr_mode_e        mode;
  mem_req_t          req;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign mode   = op_tbl_mode ? ADDR_TABLE : ADDR_RING;
  assign req.rd = op_rd_req;
  assign req.wr = op_wr_req;

  ring_sequencer #(
    .STEPS (STEPS),
    .CNT_W (OFS_W),
    .MEM_AW(MEM_AW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .step_en   (step_en),
    .len_we    (len_we),
    .len_wdata (len_wdata),
    .base_we   (base_we),
    .base_wdata(base_wdata),
    .step_idx  (step_idx),
    .step_odd  (step_odd),
    .cnt       (cnt),
    .ring_mask (ring_mask),
    .base      (base)
  );

  ring_offset_table #(
    .DEPTH(TBL_DEPTH),
    .DW   (OFS_W)
  ) u_tbl (
    .clk  (clk),
    .rst_n(rst_core_n),
    .we   (tbl_we),
    .waddr(tbl_waddr),
    .wdata(tbl_wdata),
    .raddr(op_idx),
    .rdata(offset)
  );

  ring_addr_unit #(
    .OFS_W (OFS_W),
    .AREG_W(AREG_W),
    .MEM_AW(MEM_AW)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (step_en & step_odd),
    .offset   (offset),
    .areg     (areg),
    .use_areg (op_use_areg),
    .next_word(op_next_word),
    .mode     (mode),
    .cnt      (cnt),
    .ring_mask(ring_mask),
    .base     (base),
    .addr     (mem_addr)
  );

  ring_req_pipe #(
    .MDW(MDW),
    .XW (XW)
  ) u_req (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .step_en  (step_en),
    .step_odd (step_odd),
    .req      (req),
    .mem_rdata(mem_rdata),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .rd_word  (rd_data)
  );

  // Temporary register file rotates with the sample counter.
  assign treg_idx = cnt[TEMP_W-1:0] + op_treg;

endmodule

// File: rtl/ring_agu_chk.sv
module ring_agu_chk #(
  parameter int STEPS  = 128,
  parameter int CNT_W  = 16,
  parameter int MEM_AW = 21,
  parameter int MDW    = 16,
  parameter int XW     = 24,
  parameter int STEP_W = $clog2(STEPS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en,
  input logic [STEP_W-1:0] step_idx,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  ring_mask,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [XW-1:0]     rd_data
);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_en && step_idx[0]) |=> $stable(mem_addr));

  // R5
  access_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !step_idx[0]);

  // R6
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mem_rd) |=> !mem_rd);

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mem_wr) |=> !mem_wr);

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_en && mem_rd) |=> $stable(rd_data));

  // R7
  rd_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rd_data[XW-1:MDW-1]) == 0) ||
    ($countones(rd_data[XW-1:MDW-1]) == XW - MDW + 1));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_idx == STEP_W'(STEPS - 1) && cnt == CNT_W'(1))
      |=> cnt == $past(ring_mask));

  // R12
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(step_idx) && $stable(cnt)));

endmodule

bind ring_agu ring_agu_chk #(
  .STEPS (STEPS),
  .CNT_W (OFS_W),
  .MEM_AW(MEM_AW),
  .MDW   (MDW),
  .XW    (XW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .step_en  (step_en),
  .step_idx (step_idx),
  .cnt      (cnt),
  .ring_mask(ring_mask),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .rd_data  (rd_data)
);

// File: tb/ring_agu_test.sv
module ring_agu_test;

  localparam int MEM_AW = 21;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              step_en;
  logic [5:0]        op_idx;
  logic              op_use_areg, op_next_word, op_tbl_mode;
  logic              op_rd_req, op_wr_req;
  logic [6:0]        op_treg;
  logic [11:0]       areg;
  logic              tbl_we;
  logic [5:0]        tbl_waddr;
  logic [15:0]       tbl_wdata;
  logic              len_we;
  logic [15:0]       len_wdata;
  logic              base_we;
  logic [20:0]       base_wdata;
  logic [15:0]       mem_rdata;
  logic [20:0]       mem_addr;
  logic              mem_rd, mem_wr;
  logic [23:0]       rd_data;
  logic [6:0]        treg_idx;

  always #10 clk = ~clk;

  ring_agu uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .op_idx(op_idx),
    .op_use_areg(op_use_areg), .op_next_word(op_next_word),
    .op_tbl_mode(op_tbl_mode), .op_rd_req(op_rd_req), .op_wr_req(op_wr_req),
    .op_treg(op_treg), .areg(areg), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .len_we(len_we), .len_wdata(len_wdata),
    .base_we(base_we), .base_wdata(base_wdata), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .rd_data(rd_data), .treg_idx(treg_idx)
  );

  // Sample memory model: contents are a fixed function of the address.
  function automatic logic [15:0] mem_fn(input logic [20:0] a);
    return (a[16:1] * 16'd40503) ^ {11'd0, a[20:16]};
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  int checks = 0;
  int errors = 0;

  // Behavioural reference state (value after the most recent edge).
  int m_step, m_cnt, m_len, m_base, m_addr, m_rd, m_wr, m_rdat;
  int m_off [64];
  int steps_done;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_step = 0; m_cnt = 1; m_len = 'h1FFF; m_base = 0;
    m_addr = 0; m_rd = 0; m_wr = 0; m_rdat = 0;
    for (int i = 0; i < 64; i++) m_off[i] = 0;
  endtask

  task automatic compare();
    // mem_addr covers the sum, ring and table rules: R1 R2 R3 R4
    check(mem_addr == 21'(m_addr), "R4 mem_addr", mem_addr, m_addr);
    check(mem_rd == m_rd[0], "R6 mem_rd", mem_rd, m_rd);
    check(mem_wr == m_wr[0], "R6 mem_wr", mem_wr, m_wr);
    check(rd_data == 24'(m_rdat), "R7 rd_data", rd_data, m_rdat);
    // treg_idx also exposes the counter sequence of R8
    check(treg_idx == 7'((m_cnt + op_treg) & 127), "R10 treg_idx", treg_idx, (m_cnt + op_treg) & 127);
  endtask

  // Predict the state after the coming edge from the inputs just driven.
  task automatic model_step();
    int word, w, na, c, v;
    na = m_addr;
    if (step_en) begin
      if (m_step % 2 == 1) begin                       // R5
        word = m_off[op_idx] + (op_use_areg ? int'(areg) : 0) + int'(op_next_word);
        if (!op_tbl_mode) w = (word + m_cnt) & m_len;   // R2
        else              w = word & 'hFFFF;            // R3
        na = (m_base + 2 * w) & ((1 << MEM_AW) - 1);
      end
      if (m_rd != 0) begin
        v = int'(mem_fn(21'(m_addr)));
        m_rdat = (v & 'h8000) != 0 ? (v | 'hFF0000) : v;
      end
      m_rd = (m_step % 2 == 1) && op_rd_req;
      m_wr = (m_step % 2 == 1) && op_wr_req;
      if (m_step == 127) begin                          // R8
        c = (m_cnt - 1) & 'hFFFF;
        if (c == 0) c = m_len;
        m_cnt = c;
      end
      m_step = (m_step + 1) % 128;
      m_addr = na;
      steps_done++;
    end
    if (tbl_we)  m_off[tbl_waddr] = int'(tbl_wdata);   // R11
    if (len_we)  m_len = int'(len_wdata);
    if (base_we) m_base = int'(base_wdata);
  endtask

  task automatic idle_inputs();
    step_en = 0; op_idx = 0; op_use_areg = 0; op_next_word = 0; op_tbl_mode = 0;
    op_rd_req = 0; op_wr_req = 0; op_treg = 0; areg = 0;
    tbl_we = 0; tbl_waddr = 0; tbl_wdata = 0;
    len_we = 0; len_wdata = 0; base_we = 0; base_wdata = 0;
  endtask

  task automatic rand_inputs(input bit allow_base);
    step_en      = ($urandom % 4) != 0;               // R12 stalls
    op_idx       = 6'($urandom);
    op_use_areg  = 1'($urandom);
    op_next_word = 1'($urandom);
    op_tbl_mode  = 1'($urandom);
    op_rd_req    = 1'($urandom);
    op_wr_req    = 1'($urandom);
    op_treg      = 7'($urandom);
    areg         = 12'($urandom);
    tbl_we       = ($urandom % 3) == 0;
    tbl_waddr    = ($urandom % 2) != 0 ? op_idx : 6'($urandom);  // R11 collisions
    tbl_wdata    = 16'($urandom);
    len_we       = 0;
    base_we      = allow_base && (($urandom % 64) == 0);
    base_wdata   = 21'($urandom);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    model_reset();
    steps_done = 0;
    do_reset();

    // R9: reset state at the ports
    op_treg = 7'd5;
    #1;
    check(mem_addr == 0, "R9 reset mem_addr", mem_addr, 0);
    check(mem_rd == 0 && mem_wr == 0, "R9 reset strobes", {mem_rd, mem_wr}, 0);
    check(rd_data == 0, "R9 reset rd_data", rd_data, 0);
    check(treg_idx == 7'd6, "R9 reset counter via treg_idx", treg_idx, 6);

    // Fill the offset table while stalled (R11, R12)
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      compare();
      idle_inputs();
      tbl_we = 1; tbl_waddr = 6'(i); tbl_wdata = 16'($urandom);
      model_step();
    end

    // Phase A: default ring mask, two samples plus; the first boundary reloads 0x1FFF (R8, R9)
    steps_done = 0;
    while (steps_done < 2 * 128 + 20) begin
      @(negedge clk);
      compare();
      rand_inputs(1'b1);
      model_step();
    end

    // Phase B: short ring, several reloads, non-zero base (R2, R8, R11)
    do_reset();
    @(negedge clk);
    compare();
    idle_inputs();
    len_we = 1; len_wdata = 16'd5;
    base_we = 1; base_wdata = 21'h12340;
    model_step();
    steps_done = 0;
    while (steps_done < 7 * 128 + 20) begin
      @(negedge clk);
      compare();
      rand_inputs(1'b0);
      model_step();
    end

    @(negedge clk);
    compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule